// File: doc/BRIEF.md
# Split-Read 64-bit Timestamp Counter

This block holds a free-running 64-bit cycle counter. A 32-bit register bus reads it as two halves. Software reads the lower half first and the upper half second. Between those two reads the counter keeps running, and the processor may take an interrupt. Either event can leave the two halves describing different moments in time.

To handle this, a readout tracker watches the bus reads. It records in a control/status register whether the most recent lower/upper pair is a consistent 64-bit snapshot. Software runs the sequence LOW, HIGH, CTRL and repeats it until the status bit reads 1.

A parameter sets the value the counter loads at reset (zero by default). An integration can use it to start the count at a chosen point.

Top module: `split_ts_counter`

## Requirements
- R1: Reset loads the counter with `CNT_INIT` and sets the CTRL enable bit to 1. It clears the status bit, closes the tracking window and sets `rdata_o` to 0.
- R2: A read strobe at address 0x0 returns count bits 31:0, and one at 0x4 returns bits 63:32. The value appears on `rdata_o` in the cycle after the strobe and is held until the next read. Unmapped addresses read as 0.
- R3: The counter adds one on every clock where `cnt_en_i` and CTRL bit 0 are both 1, and holds otherwise. It wraps from all ones to zero.
- R4: A LOW read opens a tracking window and discards any error recorded by an earlier window.
- R5: A pulse on `exc_i` in any cycle from the LOW read through the HIGH read makes the status bit 0 for that pair.
- R6: The status bit is 0 for a pair if the upper word changes between the reads. This is a carry out of bit 31, including the full 64-bit wrap, in any cycle from the LOW read up to the cycle before the HIGH read.
- R7: A HIGH read with no open window gives status 0. Every HIGH read closes the window.
- R8: CTRL sits at 0x8. Bit 31 is the status, and bit 0 is the counter enable, which a write strobe sets from `wdata_i[0]`. All other CTRL bits read as 0.
- R9: A CTRL read returns the result of the most recent HIGH read and leaves the tracker unchanged.
- R10: A LOW read then a HIGH read with no interrupt and no upper-word change in between gives status 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en_i | input | 1 | External counter enable |
| rd_en_i | input | 1 | Single-cycle read strobe |
| wr_en_i | input | 1 | Single-cycle write strobe |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| exc_i | input | 1 | Pulse: processor took an interrupt or exception |
| rdata_o | output | 32 | Registered read data |

## Verification
The assertions check the following on every cycle:
- The counter steps by exactly one when enabled and holds when disabled.
- A LOW read opens the window, and a HIGH read closes it.
- An orphan HIGH read, or an interrupt in the HIGH read cycle, yields a zero status.
- Cycles without a LOW or HIGH read keep the status stable.
- Reserved CTRL bits read zero, and the enable bit follows writes.

Only the bench scenarios can show the full behaviour across a window. These include:
- A carry that crosses a window, including the 64-bit wrap, marks the pair torn.
- A fresh LOW read discards an earlier error.
- Interleaved CTRL reads do not disturb the pair.
- Absolute count values match a count of the enabled cycles.

// File: rtl/ts_pkg.sv
package ts_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned ADR_W  = 4;

    localparam logic [ADR_W-1:0] OFS_LO   = 4'h0;
    localparam logic [ADR_W-1:0] OFS_HI   = 4'h4;
    localparam logic [ADR_W-1:0] OFS_CTRL = 4'h8;

    typedef enum logic [1:0] {
        SEL_LO,
        SEL_HI,
        SEL_CTRL,
        SEL_NONE
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADR_W-1:0] a);
        if (a == OFS_LO)        return SEL_LO;
        else if (a == OFS_HI)   return SEL_HI;
        else if (a == OFS_CTRL) return SEL_CTRL;
        else                    return SEL_NONE;
    endfunction
endpackage

// File: rtl/ts_count_core.sv
module ts_count_core #(
    parameter int unsigned HALF_W = 32,
    parameter logic [2*HALF_W-1:0] INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    output logic [HALF_W-1:0] lo_o,
    output logic [HALF_W-1:0] hi_o,
    output logic              hi_step_o
);
    localparam int unsigned FULL_W = 2 * HALF_W;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic carry;

    always_comb begin
        cnt_d = cnt_q;
        carry = inc_i & (&cnt_q.lo);
        if (inc_i) begin
            cnt_d.lo = cnt_q.lo + 1'b1;
        end
        if (carry) begin
            cnt_d.hi = cnt_q.hi + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= cnt_t'(INIT);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign lo_o      = cnt_q.lo;
    assign hi_o      = cnt_q.hi;
    assign hi_step_o = carry;

    // R3: one step per enabled cycle, with wrap
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> ({hi_o, lo_o} == FULL_W'($past({hi_o, lo_o}) + 1'b1)));
    // R3: hold while disabled
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable({hi_o, lo_o}));
endmodule

// File: rtl/ts_read_tracker.sv
module ts_read_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_lo_i,
    input  logic rd_hi_i,
    input  logic exc_i,
    input  logic hi_step_i,
    output logic good_o
);
    typedef struct packed {
        logic open;
        logic err;
        logic good;
    } trk_t;

    trk_t trk_d, trk_q;

    always_comb begin
        trk_d = trk_q;
        if (rd_lo_i) begin
            trk_d.open = 1'b1;
            trk_d.err  = exc_i | hi_step_i;
        end else if (rd_hi_i) begin
            trk_d.good = trk_q.open & ~trk_q.err & ~exc_i;
            trk_d.open = 1'b0;
            trk_d.err  = 1'b0;
        end else if (trk_q.open) begin
            trk_d.err = trk_q.err | exc_i | hi_step_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign good_o = trk_q.good;

    // R4: LOW read opens the window
    a_r4_open: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo_i |=> trk_q.open);
    // R7: HIGH read closes the window
    a_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_i && !rd_lo_i) |=> !trk_q.open);
    // R7: orphan HIGH read is never good
    a_r7_orphan: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_i && !trk_q.open) |=> !good_o);
    // R5: interrupt in the HIGH read cycle spoils the pair
    a_r5_exc_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_i && exc_i) |=> !good_o);
    // R9: status only moves on a HIGH read
    a_r9_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi_i |=> $stable(good_o));
endmodule

// File: rtl/ts_reg_if.sv
module ts_reg_if
    import ts_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic              good_i,
    output logic              rd_lo_o,
    output logic              rd_hi_o,
    output logic              run_en_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              run_en;
    } rif_t;

    rif_t     rif_d, rif_q;
    reg_sel_e sel;
    logic [DATA_W-1:0] ctrl_word;

    always_comb begin
        sel       = decode_addr(ADR_W'(addr_i));
        ctrl_word = '0;
        ctrl_word[DATA_W-1] = good_i;
        ctrl_word[0]        = rif_q.run_en;

        rif_d = rif_q;
        if (rd_en_i) begin
            unique case (sel)
                SEL_LO:   rif_d.rdata = lo_i;
                SEL_HI:   rif_d.rdata = hi_i;
                SEL_CTRL: rif_d.rdata = ctrl_word;
                default:  rif_d.rdata = '0;
            endcase
        end
        if (wr_en_i && sel == SEL_CTRL) begin
            rif_d.run_en = wdata_i[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rif_q.rdata  <= '0;
            rif_q.run_en <= 1'b1;
        end else begin
            rif_q <= rif_d;
        end
    end

    assign rd_lo_o  = rd_en_i && (sel == SEL_LO);
    assign rd_hi_o  = rd_en_i && (sel == SEL_HI);
    assign run_en_o = rif_q.run_en;
    assign rdata_o  = rif_q.rdata;

    // R8: reserved CTRL bits read zero
    a_r8_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(OFS_CTRL)) |=> (rdata_o[DATA_W-2:1] == '0));
    // R8: enable bit follows a CTRL write
    a_r8_en_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == ADDR_W'(OFS_CTRL)) |=> (run_en_o == $past(wdata_i[0])));
    // R2: read data is held between reads
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> $stable(rdata_o));
endmodule

// File: rtl/split_ts_counter.sv
module split_ts_counter #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 4,
    parameter logic [2*DATA_W-1:0] CNT_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en_i,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              exc_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] lo_w, hi_w;
    logic hi_step_w, good_w, rd_lo_w, rd_hi_w, run_en_w, inc_w;

    assign inc_w = cnt_en_i & run_en_w;

    ts_count_core #(.HALF_W(DATA_W), .INIT(CNT_INIT)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc_i     (inc_w),
        .lo_o      (lo_w),
        .hi_o      (hi_w),
        .hi_step_o (hi_step_w)
    );

    ts_read_tracker u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_lo_i   (rd_lo_w),
        .rd_hi_i   (rd_hi_w),
        .exc_i     (exc_i),
        .hi_step_i (hi_step_w),
        .good_o    (good_w)
    );

    ts_reg_if #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en_i  (rd_en_i),
        .wr_en_i  (wr_en_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .lo_i     (lo_w),
        .hi_i     (hi_w),
        .good_i   (good_w),
        .rd_lo_o  (rd_lo_w),
        .rd_hi_o  (rd_hi_w),
        .run_en_o (run_en_w),
        .rdata_o  (rdata_o)
    );

    // R6: an upper-word carry during an open window spoils the pair
    logic carry_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry_seen_q <= 1'b0;
        end else if (rd_lo_w) begin
            carry_seen_q <= hi_step_w;
        end else if (rd_hi_w) begin
            carry_seen_q <= 1'b0;
        end else begin
            carry_seen_q <= carry_seen_q | hi_step_w;
        end
    end
    a_r6_carry_torn: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hi_w && carry_seen_q) |=> !good_w);
endmodule

// File: tb/split_ts_counter_tb.sv
module split_ts_counter_tb;
    localparam logic [63:0] INIT = 64'hFFFF_FFFF_FFFF_FE00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_en = 1'b1;
    logic rd_en = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [31:0] wdata = '0;
    logic exc = 1'b0;
    logic [31:0] rdata;

    always #2.5 clk = ~clk;

    split_ts_counter #(.CNT_INIT(INIT)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnt_en_i(cnt_en), .rd_en_i(rd_en),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .exc_i(exc),
        .rdata_o(rdata)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];

    int n_cmp = 0;
    int n_bad = 0;
    string cur_tag = "";

    // reference model built from the requirements
    logic [63:0] m_cnt;
    logic        m_en, m_open, m_exc, m_good;
    logic [31:0] m_hi_at_lo;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= INIT; m_en <= 1'b1; m_open <= 1'b0;
            m_exc <= 1'b0; m_good <= 1'b0; m_hi_at_lo <= '0;
        end else begin
            item_t it;
            if (cnt_en && m_en) m_cnt <= m_cnt + 64'd1;
            if (wr_en && addr == 4'h8) m_en <= wdata[0];
            if (rd_en) begin
                it.tag = cur_tag;
                case (addr)
                    4'h0: it.exp = m_cnt[31:0];
                    4'h4: it.exp = m_cnt[63:32];
                    4'h8: it.exp = {m_good, 30'd0, m_en};
                    default: it.exp = 32'd0;
                endcase
                sb_q.push_back(it);
            end
            if (rd_en && addr == 4'h0) begin
                m_open <= 1'b1; m_exc <= exc; m_hi_at_lo <= m_cnt[63:32];
            end else if (rd_en && addr == 4'h4) begin
                m_good <= m_open && !(m_exc || exc) && (m_cnt[63:32] == m_hi_at_lo);
                m_open <= 1'b0; m_exc <= 1'b0;
            end else begin
                m_exc <= m_exc | exc;
            end
        end
    end

    // monitor
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_cmp++;
            if (rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", it.tag, rdata, it.exp);
            end
        end
    end

    task automatic rd(input logic [3:0] a, input string t, input bit ex = 1'b0);
        @(negedge clk);
        rd_en = 1'b1; addr = a; exc = ex; cur_tag = t;
        @(negedge clk);
        rd_en = 1'b0; exc = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = 4'h8; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_exc();
        @(negedge clk); exc = 1'b1;
        @(negedge clk); exc = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        idle(3);
        n_cmp++;
        if (rdata !== 32'd0) begin
            n_bad++;
            $display("FAIL R1: got %h expected %h", rdata, 32'd0);
        end
        rst_n = 1'b1;
        rd(4'h8, "R1 ctrl after reset");
        // clean pair
        rd(4'h0, "R2 low");
        rd(4'h4, "R2 high");
        rd(4'h8, "R10 clean pair");
        rd(4'hC, "R2 unmapped");
        // interrupt between reads
        rd(4'h0, "R2 low");
        pulse_exc();
        rd(4'h4, "R2 high");
        rd(4'h8, "R5 exc between");
        // interrupt in the HIGH cycle
        rd(4'h0, "R2 low");
        rd(4'h4, "R2 high", 1'b1);
        rd(4'h8, "R5 exc on high");
        // LOW restart drops a stale error
        rd(4'h0, "R2 low");
        pulse_exc();
        rd(4'h0, "R4 low restart");
        rd(4'h4, "R2 high");
        rd(4'h8, "R4 error cleared");
        // orphan HIGH
        rd(4'h4, "R7 orphan high");
        rd(4'h8, "R7 orphan status");
        // CTRL interleaved
        rd(4'h0, "R2 low");
        rd(4'h8, "R9 ctrl mid window");
        rd(4'h4, "R2 high");
        rd(4'h8, "R9 pair intact");
        rd(4'h8, "R9 repeat ctrl");
        // external disable
        cnt_en = 1'b0;
        rd(4'h0, "R3 hold ext");
        idle(5);
        rd(4'h0, "R3 hold ext again");
        cnt_en = 1'b1;
        // CTRL disable
        wr_ctrl(32'hFFFF_FFFE);
        rd(4'h8, "R8 enable cleared");
        rd(4'h0, "R3 hold ctrl");
        idle(4);
        rd(4'h0, "R3 hold ctrl again");
        wr_ctrl(32'h0000_0001);
        rd(4'h8, "R8 enable set");
        // carry across the window, including the 64-bit wrap
        rd(4'h0, "R2 low before wrap");
        idle(600);
        rd(4'h4, "R3 high after wrap");
        rd(4'h8, "R6 torn by carry");
        // retry yields a clean pair
        rd(4'h0, "R2 low");
        rd(4'h4, "R2 high");
        rd(4'h8, "R10 retry clean");
        idle(3);
        finish_run();
    end
endmodule